// File: doc/BRIEF.md
# Pin Input Qualification Filter

This block conditions a single asynchronous pin before its level is handed to the data-read path, the peripheral inputs and the external-interrupt selection logic. A 2-bit mode select, which may change at run time, picks one of four treatments. The pin can be synchronized to the system clock only. It can be filtered so that a new level is accepted only after three agreeing samples, or only after six. It can also pass straight through with no clocking at all.

The filter modes do not sample on every clock. A period divider paces them. A period value of zero samples on every clock, and a value of N takes one sample every 2N clocks. A two-flop synchronizer always feeds the filter, and a short history register keeps the most recent synchronized samples. While the block runs in a non-filter mode, the held filter level follows the synchronized pin. A switch into a filter mode therefore starts from the pin's present level and not from a stale one.

Top module: `inputQualifier`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the qualified output is 0 and every stored sample is 0, even when the pin is held at 1.
- R2: Mode code 2'b00 (the reset default) gives an output equal to the pin level two system clocks earlier, through a two-flop synchronizer, independent of the sampling period.
- R3: Mode code 2'b01 changes the output only at a sample tick at which the newest three synchronized samples all equal the new level. Between ticks, and at a tick whose three samples disagree, the output is held.
- R4: Mode code 2'b10 behaves as R3 but requires the newest six synchronized samples to agree.
- R5: Mode code 2'b11 drives the output combinationally from the raw pin, with no clock delay.
- R6: A sampling-period value of 0 takes a filter sample on every clock. A value N > 0 takes one sample every 2N clocks.
- R7: A pin pulse shorter than the agreement window of the active filter mode leaves the qualified output unchanged.
- R8: On a clock where the period value differs from its value on the previous clock, no sample is taken and the period counter restarts. The next sample falls 2N clocks later for the new value N, or one clock later for a value of 0.
- R9: In modes 2'b00 and 2'b11 the held filter level tracks the synchronized pin every clock. After a switch into 2'b01 or 2'b10, the output therefore starts at the synchronized level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | 1 | Raw asynchronous pin level |
| modeSel | input | 2 | Qualification mode: 00 sync, 01 three samples, 10 six samples, 11 bypass |
| periodSel | input | PERIOD_W (8) | Sampling period: 0 means every clock, N means every 2N clocks |
| qualOut | output | 1 | Qualified pin level |

## Verification
Two functions can fall on the same clock. A change of the period value can land on the very cycle in which the divider would otherwise issue a sample tick. A mode switch can coincide with a sample that would complete or break an agreement window. The bench provokes both: it rewrites the period every few clocks at offsets that sweep across the tick position, and it switches modes on a fixed seven-clock stride while the pin toggles randomly. A behavioural model of counter, history and held level is compared with the output at every clock, so a tick that is dropped, doubled or misplaced, or a wrong starting level after a switch, shows up as a mismatch.

// File: rtl/inQualPkg.sv
package inQualPkg;

  typedef enum logic [1:0] {
    QM_SYNC   = 2'b00,
    QM_FILT_A = 2'b01,
    QM_FILT_B = 2'b10,
    QM_ASYNC  = 2'b11
  } qualMode_e;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic sample;    // take one filter sample this clock
    logic track;     // held level follows the synchronizer
    logic useShort;  // short agreement window active
    logic useLong;   // long agreement window active
    logic bypass;    // raw pin to output
    logic passSync;  // synchronizer output to output
  } qualStrobe_t;

endpackage

// File: rtl/qualCtrl.sv
module qualCtrl
  import inQualPkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          modeIn,
  input  logic [PERIOD_W-1:0] periodIn,
  output qualStrobe_t         strobeOut
);
  localparam int CNT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] lastPeriodQ;
  logic [CNT_W-1:0]    cntQ;
  logic [CNT_W-1:0]    limit;
  logic                periodChanged;
  logic                sampleHit;

  always_comb begin
    if (periodIn == '0) limit = '0;
    else                limit = ({1'b0, periodIn} << 1) - CNT_W'(1);
    periodChanged = (periodIn != lastPeriodQ);
    sampleHit     = !periodChanged && (cntQ == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastPeriodQ <= '0;
      cntQ        <= '0;
    end else begin
      lastPeriodQ <= periodIn;
      if (periodChanged || sampleHit) cntQ <= '0;
      else                            cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_comb begin
    strobeOut.sample   = sampleHit;
    strobeOut.bypass   = (modeIn == QM_ASYNC);
    strobeOut.passSync = (modeIn == QM_SYNC);
    strobeOut.track    = (modeIn == QM_SYNC) || (modeIn == QM_ASYNC);
    strobeOut.useShort = (modeIn == QM_FILT_A);
    strobeOut.useLong  = (modeIn == QM_FILT_B);
  end

  // R8: a period change restarts the counter on the following clock
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    periodChanged |=> (cntQ == '0));

  // R6: outside a change cycle the counter never passes the period limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    !periodChanged |-> (cntQ <= limit));

  // R6: a steady zero period yields a tick every clock
  a_r6_every_clock: assert property (@(posedge clk) disable iff (rst)
    (periodIn == '0 && lastPeriodQ == '0) |-> strobeOut.sample);

endmodule

// File: rtl/qualPath.sv
module qualPath
  import inQualPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CNT   = 3,
  parameter int LONG_CNT    = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pinIn,
  input  qualStrobe_t strobeIn,
  output logic        qualOut
);
  localparam int HIST_D = (LONG_CNT > SHORT_CNT) ? LONG_CNT : SHORT_CNT;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [HIST_D-1:0]      histQ;
  logic [HIST_D-1:0]      window;
  logic                   qualQ;
  logic                   shortAgree;
  logic                   longAgree;
  logic                   accept;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];
  // window seen at a tick: newest sample plus the stored ones
  assign window  = {histQ[HIST_D-2:0], syncOut};

  always_comb begin
    shortAgree = (&window[SHORT_CNT-1:0]) || !(|window[SHORT_CNT-1:0]);
    longAgree  = (&window[LONG_CNT-1:0])  || !(|window[LONG_CNT-1:0]);
    accept     = strobeIn.sample &&
                 ((strobeIn.useShort && shortAgree) ||
                  (strobeIn.useLong  && longAgree));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      histQ <= '0;
      qualQ <= 1'b0;
    end else begin
      if (strobeIn.sample) histQ <= window;
      if (strobeIn.track || accept) qualQ <= syncOut;
    end
  end

  always_comb begin
    if (strobeIn.bypass)        qualOut = pinIn;
    else if (strobeIn.passSync) qualOut = syncOut;
    else                        qualOut = qualQ;
  end

  // R3/R4: a filter mode without a tick holds the level
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    ((strobeIn.useShort || strobeIn.useLong) && !strobeIn.sample)
      |=> $stable(qualQ));

  // R3: a new level in the short mode is backed by three stored samples
  a_r3_agree: assert property (@(posedge clk) disable iff (rst)
    ($past(strobeIn.useShort) && (qualQ != $past(qualQ)))
      |-> (histQ[SHORT_CNT-1:0] == {SHORT_CNT{qualQ}}));

  // R4: a new level in the long mode is backed by six stored samples
  a_r4_agree: assert property (@(posedge clk) disable iff (rst)
    ($past(strobeIn.useLong) && (qualQ != $past(qualQ)))
      |-> (histQ[LONG_CNT-1:0] == {LONG_CNT{qualQ}}));

endmodule

// File: rtl/inputQualifier.sv
module inputQualifier
  import inQualPkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CNT   = 3,
  parameter int LONG_CNT    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pinIn,
  input  logic [1:0]          modeSel,
  input  logic [PERIOD_W-1:0] periodSel,
  output logic                qualOut
);
  qualStrobe_t strobe;

  qualCtrl #(.PERIOD_W(PERIOD_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .modeIn   (modeSel),
    .periodIn (periodSel),
    .strobeOut(strobe)
  );

  qualPath #(
    .SYNC_STAGES(SYNC_STAGES),
    .SHORT_CNT  (SHORT_CNT),
    .LONG_CNT   (LONG_CNT)
  ) path_i (
    .clk     (clk),
    .rst     (rst),
    .pinIn   (pinIn),
    .strobeIn(strobe),
    .qualOut (qualOut)
  );

  // R5: bypass mode presents the raw pin at once
  always_comb begin
    if (!rst && modeSel == 2'b11)
      a_r5_bypass: assert (qualOut == pinIn);
  end

endmodule

// File: tb/inputQualifier_tb_top.sv
`timescale 1ns/100ps
module inputQualifier_tb_top;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pinIn = 1'b0;
  logic [1:0]    modeSel = 2'b00;
  logic [PW-1:0] periodSel = '0;
  logic          qualOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit checkEn = 0;
  string phaseTag = "R1";

  always #2.5 clk = ~clk;

  inputQualifier #(.PERIOD_W(PW)) dut_i (
    .clk(clk), .rst(rst), .pinIn(pinIn),
    .modeSel(modeSel), .periodSel(periodSel), .qualOut(qualOut)
  );

  // behavioural reference state
  int mS1, mS2, mCnt, mPrev, mQual, mLim, mNeed;
  int mHist[6];
  bit mChg, mStb, mAgree;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mS1 = 0; mS2 = 0; mCnt = 0; mPrev = 0; mQual = 0;
      foreach (mHist[i]) mHist[i] = 0;
    end else begin
      mChg = (int'(periodSel) != mPrev);
      mLim = (periodSel == 0) ? 0 : 2 * int'(periodSel) - 1;
      mStb = !mChg && (mCnt == mLim);
      if (mStb) begin
        for (int i = 5; i > 0; i--) mHist[i] = mHist[i-1];
        mHist[0] = mS2;
        mNeed = (modeSel == 2'b01) ? 3 : (modeSel == 2'b10) ? 6 : 0;
        if (mNeed > 0) begin
          mAgree = 1;
          for (int i = 0; i < mNeed; i++) if (mHist[i] != mS2) mAgree = 0;
          if (mAgree) mQual = mS2;
        end
      end
      if (modeSel == 2'b00 || modeSel == 2'b11) mQual = mS2;
      mCnt = (mChg || mStb) ? 0 : mCnt + 1;
      mPrev = int'(periodSel);
      mS2 = mS1;
      mS1 = int'(pinIn);
    end
  end

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: qualOut=%0d expected %0d", req, cycles, act, exp);
    end
  endtask

  // compare with the model in mid-cycle, every clock
  always @(negedge clk) begin
    if (checkEn && !rst)
      check({modeTag(modeSel), "/", phaseTag}, int'(qualOut),
            (modeSel == 2'b11) ? int'(pinIn) : (modeSel == 2'b00) ? mS2 : mQual);
  end

  task automatic step(input logic p);
    @(posedge clk); #1 pinIn = p;
  endtask

  task automatic randRun(input int n, input int holdMax);
    for (int i = 0; i < n; i++) begin
      logic v = 1'($urandom);
      int h = 1 + int'($urandom % holdMax);
      for (int j = 0; j < h; j++) step(v);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
    finishRun();
  end

  initial begin
    // R1: reset with the pin held high
    pinIn = 1'b1; modeSel = 2'b01;
    repeat (4) @(posedge clk);
    #1 check("R1 during reset", int'(qualOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", int'(qualOut), 0);
    checkEn = 1;

    phaseTag = "R2"; modeSel = 2'b00;
    randRun(40, 4);
    phaseTag = "R5"; modeSel = 2'b11;
    randRun(30, 3);
    phaseTag = "R6 period0"; modeSel = 2'b01; periodSel = 0;
    randRun(60, 5);
    modeSel = 2'b10;
    randRun(60, 9);
    phaseTag = "R6 period3"; modeSel = 2'b01; periodSel = 3;
    randRun(40, 24);
    phaseTag = "R6 period1"; modeSel = 2'b10; periodSel = 1;
    randRun(40, 16);

    // R7: short pulse against a settled long window
    phaseTag = "R7"; periodSel = 0; modeSel = 2'b10;
    repeat (12) step(1'b1);
    step(1'b0); step(1'b0); step(1'b0);
    repeat (3) step(1'b1);
    @(negedge clk);
    check("R7 pulse ignored", int'(qualOut), 1);
    modeSel = 2'b01;
    step(1'b0); step(1'b0); step(1'b1);
    repeat (3) step(1'b1);
    @(negedge clk);
    check("R7 two-clock pulse ignored", int'(qualOut), 1);

    // R8: period rewrites sweeping across the tick position
    phaseTag = "R8";
    for (int k = 0; k < 40; k++) begin
      periodSel = PW'(1 + (k % 4));
      modeSel = (k % 2 == 0) ? 2'b01 : 2'b10;
      for (int j = 0; j < 1 + (k % 9); j++) step(1'($urandom));
    end

    // R9: mode switches on a seven-clock stride
    phaseTag = "R9"; periodSel = 1;
    for (int k = 0; k < 40; k++) begin
      modeSel = 2'(k);
      for (int j = 0; j < 7; j++) step(1'($urandom));
    end

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule